// File: doc/BRIEF.md
# Panel Window and Orientation Command Writer

This block produces the short command sequences that a small 176 x 220 colour panel controller needs before pixel data can flow. On a window request it sends the column range command, the row range command and then the command that opens frame memory for writing. On an orientation request it sends the memory access control command, with one parameter byte that encodes the rotation and the red/blue order.

Bytes leave through a valid/ready stream toward a serial link driver. Each byte carries a flag that tells the driver whether it is a command or a parameter. The block drives `out_valid` only while it is busy. The byte and its flag are held steady until `out_ready` accepts them, so the downstream driver may stall for any number of cycles. Requests are levels. The requester holds a request until it sees `busy` rise, and a request raised during a transfer simply waits.

Top module: `lcd_win_rot_writer`

## Requirements
- R1: After reset, `out_valid`, `busy` and `done` are all 0.
- R2: A window transfer emits 11 bytes in this order. First command 2Ah, then the parameters 00h, x_start, 00h, x_end. Next command 2Bh, then the parameters 00h, y_start, 00h, y_end. Last, command 2Ch. `out_is_cmd` is 1 on the three command bytes and 0 on the parameters.
- R3: An orientation transfer emits command 36h and then one parameter byte. In that byte, bit 7 is row flip, bit 6 is column flip, bit 5 is row/column swap, bit 3 is `bgr`, and all other bits are 0. `rot_code` 0 (0 degrees) sets no flip bits. Code 1 (90 degrees) sets bits 7 and 5. Code 2 (180 degrees) sets bits 7 and 6. Code 3 (270 degrees) sets bits 6 and 5.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_byte` and `out_is_cmd` hold their values. The sequence advances by one byte only on a cycle where both are 1.
- R5: A request is accepted only on a clock edge where `busy` is 0. A request that is held high during a transfer is accepted on the first such edge after the transfer ends.
- R6: If `win_req` and `rot_req` are both high at an accepting edge, the window transfer runs first.
- R7: `done` is 1 for exactly one cycle, in the cycle after the final byte's handshake. `busy` and `out_valid` fall in that same cycle.
- R8: Coordinates, `rot_code` and `bgr` are captured when the request is accepted. Changing them during a transfer has no effect on the bytes of that transfer.
- R9: `busy` is 1 from the cycle after acceptance until the cycle in which `done` is raised. `out_valid` is never 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_req | input | 1 | Request a window transfer (level) |
| x_start | input | 8 | First column |
| x_end | input | 8 | Last column |
| y_start | input | 8 | First row |
| y_end | input | 8 | Last row |
| rot_req | input | 1 | Request an orientation transfer (level) |
| rot_code | input | 2 | 0/1/2/3 = 0/90/180/270 degrees |
| bgr | input | 1 | Blue-first colour order |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Downstream accepts the byte |
| out_byte | output | 8 | Command or parameter byte |
| out_is_cmd | output | 1 | 1 = command byte, 0 = parameter |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |

## Verification
The hardest case to reach is a request that meets the exact cycle where one transfer finishes, while the caller changes the coordinates mid-transfer. The bench starts a window, stalls the stream, and then applies new coordinates together with a held window request. It checks that the running transfer still shows the old values. It then checks that the new window starts right after the `done` pulse. A second scenario raises both requests in the same idle cycle and checks that the orientation bytes follow only after the whole window sequence.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;
  localparam int BYTE_W  = 8;
  localparam int COORD_W = 8;
  localparam int IDX_W   = 4;
  localparam int WIN_LEN = 11;
  localparam int ROT_LEN = 2;

  localparam logic [BYTE_W-1:0] OP_COLS  = 8'h2A;
  localparam logic [BYTE_W-1:0] OP_ROWS  = 8'h2B;
  localparam logic [BYTE_W-1:0] OP_WRITE = 8'h2C;
  localparam logic [BYTE_W-1:0] OP_ORIENT = 8'h36;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_WIN  = 2'd1,
    MODE_ROT  = 2'd2
  } mode_e;

  typedef struct packed {
    logic [COORD_W-1:0] xs;
    logic [COORD_W-1:0] xe;
    logic [COORD_W-1:0] ys;
    logic [COORD_W-1:0] ye;
  } window_t;
endpackage

// File: rtl/lcdw_orient_enc.sv
module lcdw_orient_enc
  import lcdw_pkg::*;
(
  input  logic [1:0]        rot_code,
  input  logic              bgr,
  output logic [BYTE_W-1:0] param
);
  logic flip_row, flip_col, swap;

  always_comb begin
    unique case (rot_code)
      2'd0: {flip_row, flip_col, swap} = 3'b000;
      2'd1: {flip_row, flip_col, swap} = 3'b101;
      2'd2: {flip_row, flip_col, swap} = 3'b110;
      default: {flip_row, flip_col, swap} = 3'b011;
    endcase
    param = {flip_row, flip_col, swap, 1'b0, bgr, 3'b000};
  end
endmodule

// File: rtl/lcdw_window_bytes.sv
module lcdw_window_bytes
  import lcdw_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  window_t           win,
  output logic [BYTE_W-1:0] byte_o,
  output logic              is_cmd
);
  always_comb begin
    is_cmd = 1'b0;
    byte_o = '0;
    unique case (idx)
      4'd0:  begin byte_o = OP_COLS;  is_cmd = 1'b1; end
      4'd2:  byte_o = win.xs;
      4'd4:  byte_o = win.xe;
      4'd5:  begin byte_o = OP_ROWS;  is_cmd = 1'b1; end
      4'd7:  byte_o = win.ys;
      4'd9:  byte_o = win.ye;
      4'd10: begin byte_o = OP_WRITE; is_cmd = 1'b1; end
      default: byte_o = '0;
    endcase
  end
endmodule

// File: rtl/lcdw_step_ctr.sv
module lcdw_step_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         adv,
  input  logic [W-1:0] len,
  output logic [W-1:0] idx,
  output logic         last
);
  always_ff @(posedge clk) begin
    if (!rst_n)      idx <= '0;
    else if (start)  idx <= '0;
    else if (adv)    idx <= last ? '0 : idx + 1'b1;
  end

  assign last = (idx == len - 1'b1);
endmodule

// File: rtl/lcd_win_rot_writer.sv
module lcd_win_rot_writer
  import lcdw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               win_req,
  input  logic [COORD_W-1:0] x_start,
  input  logic [COORD_W-1:0] x_end,
  input  logic [COORD_W-1:0] y_start,
  input  logic [COORD_W-1:0] y_end,
  input  logic               rot_req,
  input  logic [1:0]         rot_code,
  input  logic               bgr,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [BYTE_W-1:0]  out_byte,
  output logic               out_is_cmd,
  output logic               busy,
  output logic               done
);
  localparam logic [IDX_W-1:0] WIN_LEN_V = IDX_W'(WIN_LEN);
  localparam logic [IDX_W-1:0] ROT_LEN_V = IDX_W'(ROT_LEN);

  mode_e              mode;
  window_t            win_q;
  logic [1:0]         rot_q;
  logic               bgr_q;
  logic               accept, hs, last;
  logic [IDX_W-1:0]   idx, len;
  logic [BYTE_W-1:0]  win_byte, orient_param;
  logic               win_cmd;

  assign accept = (mode == MODE_IDLE) && (win_req || rot_req);
  assign hs     = out_valid && out_ready;
  assign len    = (mode == MODE_ROT) ? ROT_LEN_V : WIN_LEN_V;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode  <= MODE_IDLE;
      done  <= 1'b0;
      win_q <= '0;
      rot_q <= '0;
      bgr_q <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (mode)
        MODE_IDLE: begin
          if (win_req) begin
            mode  <= MODE_WIN;
            win_q <= '{xs: x_start, xe: x_end, ys: y_start, ye: y_end};
          end else if (rot_req) begin
            mode  <= MODE_ROT;
            rot_q <= rot_code;
            bgr_q <= bgr;
          end
        end
        default: begin
          if (hs && last) begin
            mode <= MODE_IDLE;
            done <= 1'b1;
          end
        end
      endcase
    end
  end

  lcdw_step_ctr #(.W(IDX_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start(accept), .adv(hs),
    .len(len), .idx(idx), .last(last)
  );

  lcdw_window_bytes u_win (
    .idx(idx), .win(win_q), .byte_o(win_byte), .is_cmd(win_cmd)
  );

  lcdw_orient_enc u_enc (
    .rot_code(rot_q), .bgr(bgr_q), .param(orient_param)
  );

  assign busy      = (mode != MODE_IDLE);
  assign out_valid = busy;

  always_comb begin
    if (mode == MODE_ROT) begin
      out_is_cmd = (idx == '0);
      out_byte   = (idx == '0) ? OP_ORIENT : orient_param;
    end else begin
      out_is_cmd = win_cmd;
      out_byte   = win_byte;
    end
  end
endmodule

// File: rtl/lcd_win_rot_writer_chk.sv
module lcd_win_rot_writer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       win_req,
  input logic       rot_req,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte,
  input logic       out_is_cmd,
  input logic       busy,
  input logic       done
);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_is_cmd));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_hs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(out_valid && out_ready));

  assert_valid_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  assert_start_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(win_req || rot_req) && out_is_cmd);

  assert_cmd_codes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_cmd |->
      (out_byte == 8'h2A || out_byte == 8'h2B || out_byte == 8'h2C || out_byte == 8'h36));
endmodule

bind lcd_win_rot_writer lcd_win_rot_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .win_req(win_req), .rot_req(rot_req),
  .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
  .out_is_cmd(out_is_cmd), .busy(busy), .done(done)
);

// File: tb/lcd_win_rot_writer_tb.sv
module lcd_win_rot_writer_tb;
  logic clk = 0, rst_n = 0;
  logic win_req = 0, rot_req = 0, bgr = 0, out_ready = 0;
  logic [7:0] x_start = 0, x_end = 0, y_start = 0, y_end = 0;
  logic [1:0] rot_code = 0;
  logic out_valid, out_is_cmd, busy, done;
  logic [7:0] out_byte;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] cap_b [16];
  logic       cap_c [16];

  always #2.5 clk = ~clk;

  lcd_win_rot_writer u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // collect n handshaken bytes; stall != 0 inserts ready gaps
  task automatic collect(input int n, input bit stall);
    int got = 0, k = 0;
    bit prev_st = 0;
    logic [7:0] prev_b = 0;
    while (got < n) begin
      @(negedge clk);
      out_ready = stall ? (k % 3 != 0) : 1'b1;
      k++;
      #1;
      if (prev_st) check(out_valid && out_byte == prev_b, "R4", out_byte, prev_b);
      prev_st = out_valid && !out_ready;
      prev_b  = out_byte;
      if (out_valid && out_ready) begin
        cap_b[got] = out_byte; cap_c[got] = out_is_cmd; got++;
      end
      if (k > 200) break;
    end
    @(negedge clk); out_ready = 0; #1;
    check(done && !busy && !out_valid, "R7", {done, busy, out_valid}, 3'b100);
    @(negedge clk); #1;
    check(!done, "R7", done, 0);
  endtask

  task automatic check_win(input logic [7:0] xs, xe, ys, ye, input string tag);
    logic [7:0] eb [11];
    bit ec [11];
    eb = '{8'h2A, 0, xs, 0, xe, 8'h2B, 0, ys, 0, ye, 8'h2C};
    ec = '{1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1};
    for (int i = 0; i < 11; i++)
      check(cap_b[i] == eb[i] && cap_c[i] == ec[i], tag, {cap_c[i], cap_b[i]}, {ec[i], eb[i]});
  endtask

  task automatic issue_win(input logic [7:0] xs, xe, ys, ye);
    @(negedge clk);
    x_start = xs; x_end = xe; y_start = ys; y_end = ye; win_req = 1;
    @(negedge clk); win_req = 0; #1;
    check(busy, "R9", busy, 1);
  endtask

  task automatic t_reset();
    #1;
    check(!out_valid && !busy && !done, "R1", {out_valid, busy, done}, 0);
  endtask

  task automatic t_window_plain();
    issue_win(8'd0, 8'd175, 8'd0, 8'd219);
    collect(11, 0);
    check_win(8'd0, 8'd175, 8'd0, 8'd219, "R2");
  endtask

  task automatic t_window_stall();
    issue_win(8'd10, 8'd20, 8'd30, 8'd40);
    collect(11, 1);
    check_win(8'd10, 8'd20, 8'd30, 8'd40, "R2_stall_R4");
  endtask

  task automatic t_rotations();
    logic [7:0] exp_flags [4];
    exp_flags = '{8'h00, 8'hA0, 8'hC0, 8'h60};
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 4; r++) begin
        @(negedge clk); rot_code = r[1:0]; bgr = b[0]; rot_req = 1;
        @(negedge clk); rot_req = 0;
        collect(2, b[0]);
        check(cap_b[0] == 8'h36 && cap_c[0], "R3", cap_b[0], 8'h36);
        check(cap_b[1] == (exp_flags[r] | (b[0] ? 8'h08 : 8'h00)) && !cap_c[1], "R3",
              cap_b[1], exp_flags[r] | (b[0] ? 8'h08 : 8'h00));
      end
  endtask

  task automatic t_holdoff();
    issue_win(8'd1, 8'd2, 8'd3, 8'd4);
    @(negedge clk);
    x_start = 8'd50; x_end = 8'd60; y_start = 8'd70; y_end = 8'd80; win_req = 1;
    rot_code = 2'd3;
    collect(11, 1);
    check_win(8'd1, 8'd2, 8'd3, 8'd4, "R8");
    win_req = 0; #1;
    check(busy, "R5", busy, 1);
    collect(11, 0);
    check_win(8'd50, 8'd60, 8'd70, 8'd80, "R5");
  endtask

  task automatic t_both();
    @(negedge clk);
    x_start = 8'd5; x_end = 8'd6; y_start = 8'd7; y_end = 8'd8;
    rot_code = 2'd1; bgr = 1; win_req = 1; rot_req = 1;
    @(negedge clk); win_req = 0;
    collect(11, 0);
    check_win(8'd5, 8'd6, 8'd7, 8'd8, "R6");
    rot_req = 0;
    collect(2, 0);
    check(cap_b[0] == 8'h36 && cap_b[1] == 8'hA8, "R6", {cap_b[0], cap_b[1]}, 16'h36A8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_window_plain();
    t_window_stall();
    t_rotations();
    t_holdoff();
    t_both();
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule